// File: doc/BRIEF.md
# ISA Plug-and-Play Card Configuration Controller

This block is the card-side configuration engine for a plug-and-play expansion card on an 8-bit ISA-style I/O bus. Host software reaches the card's configuration space with an indirect scheme. It first writes a register index to a fixed pointer port. It then writes through a fixed write port, or reads through a read port whose location software can move. The block tracks the card through four states: wait-for-key, sleep, isolation and configuration. It holds the card-select number, the selected logical device number and the relocatable read-port address.

The external initiation-key detector is reduced to a one-cycle `key_hit` pulse. Card isolation is reduced to a serial walk over a card identifier, one bit for each read. Resource-description bytes come from an upstream source through a valid/ready pair, and a byte is consumed when software reads it. Bus cycles are single-clock strobes: `bus_rd` and `bus_wr` are active high, and `bus_aen` high marks a DMA cycle.

Top module: `pnp_cfg_fsm`

## Requirements
- R1: While `rst` is high and after it falls, `card_state` is 0 (wait-for-key), `ldev_num` is 0, the card-select number and read-port address are 0, and `bus_rdrive` is low. The state encoding is 0 = wait-for-key, 1 = sleep, 2 = isolation, 3 = configuration.
- R2: In wait-for-key, writes to the pointer port and the write-data port are ignored, and read-port reads leave `bus_rdrive` low. A `key_hit` pulse in that state moves the card to sleep (1) on the next clock, and that is the only exit from wait-for-key.
- R3: Any bus cycle with `bus_aen` high is ignored: the pointer and the registers keep their values, `bus_rdrive` stays low and no resource byte is consumed.
- R4: A write to port 0x0279 loads the register pointer. Writes to port 0x0A79 and reads from the read port then reach the pointed register, repeatedly, without the pointer being written again.
- R5: Writing register 0x00 sets the read-port address to {data[7:0], 2'b11}, which is address bits 9..2 from the data. The write takes effect only in isolation. Read-port cycles are answered only in isolation or configuration.
- R6: Writing register 0x03 with data equal to the card-select number moves the card to isolation if the data is 0, or to configuration otherwise, and restarts the identifier walk at bit 0. Data that does not match moves the card to sleep.
- R7: In isolation, each read of register 0x01 returns 0x55 for an identifier bit of 1 and 0xAA for a bit of 0, starting at bit 0 and advancing one bit per read. After all ID_W bits it returns 0x00.
- R8: Register 0x06 holds the card-select number and reads back. A write in isolation also moves the card to configuration.
- R9: Register 0x07 holds the logical device number, is writable in configuration, reads back, and is driven on `ldev_num`. It changes only on a write.
- R10: In register 0x02, bit 2 clears the card-select number and the read-port address, and bit 1 returns the card to wait-for-key while the card-select number and logical device number are kept. Bit 0 gives a one-cycle `ld_restore` pulse. The register reads as 0.
- R11: Register 0x05 reads {7'b0, res_valid}. A read of register 0x04 returns `res_data` and raises `res_ready` in that cycle when `res_valid` is high, and returns 0 with no handshake otherwise.
- R12: Reads of write-only or unimplemented registers (0x00, 0x02, 0x03, 0x08 and above) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_aen | input | 1 | DMA address enable; cycle ignored when high |
| key_hit | input | 1 | Initiation key detected pulse |
| card_id | input | 72 | Card serial identifier, bit 0 sent first |
| res_data | input | 8 | Resource-data byte |
| res_valid | input | 1 | Resource byte available |
| res_ready | output | 1 | Resource byte consumed this cycle |
| bus_rdata | output | 8 | Read data, zero when not driven |
| bus_rdrive | output | 1 | Read data is being driven |
| card_state | output | 2 | Card state |
| ldev_num | output | 8 | Selected logical device number |
| ld_restore | output | 1 | Pulse to restore logical-device defaults |

## Verification
The bench builds the block with its default parameters: a 72-bit identifier, a 16-bit address and the standard pointer and write-data port addresses. With these values it walks the full 72-read isolation sequence and checks the read that follows the last bit. It also moves the read port away from and back to its zero address, so it can check that decoding follows the relocation. Every state transition is reached, including the mismatched wake into sleep and the return to wait-for-key, and the resource handshake is run with `res_valid` both low and high.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WFK   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ISO   = 2'd2,
        ST_CFG   = 2'd3
    } card_st_e;

    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_ISO    = 8'h01;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_WAKE   = 8'h03;
    localparam logic [7:0] IDX_RES    = 8'h04;
    localparam logic [7:0] IDX_STAT   = 8'h05;
    localparam logic [7:0] IDX_CSN    = 8'h06;
    localparam logic [7:0] IDX_LDN    = 8'h07;

    localparam logic [7:0] ISO_ONE  = 8'h55;
    localparam logic [7:0] ISO_ZERO = 8'hAA;

    typedef struct packed {
        card_st_e   st;
        logic [7:0] ptr;
        logic [7:0] csn;
        logic [7:0] ldn;
        logic [7:0] rdport;
        logic       restore;
    } core_t;

endpackage

// File: rtl/pnp_port_dec.sv
module pnp_port_dec #(
    parameter int              ADDR_W     = 16,
    parameter logic [15:0]     PTR_PORT   = 16'h0279,
    parameter logic [15:0]     WDATA_PORT = 16'h0A79
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_aen,
    input  logic [7:0]        rd_base,
    input  logic              wr_allow,
    input  logic              rd_allow,
    output logic              ptr_we,
    output logic              data_we,
    output logic              data_re
);
    localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_PORT);
    localparam logic [ADDR_W-1:0] WD_A  = ADDR_W'(WDATA_PORT);

    logic [ADDR_W-1:0] rd_a;
    logic              live;

    always_comb begin
        rd_a    = ADDR_W'({rd_base, 2'b11});
        live    = !bus_aen;
        ptr_we  = live && bus_wr && wr_allow && (bus_addr == PTR_A);
        data_we = live && bus_wr && wr_allow && (bus_addr == WD_A);
        data_re = live && bus_rd && rd_allow && (bus_addr == rd_a);
    end
endmodule

// File: rtl/pnp_iso_seq.sv
module pnp_iso_seq #(
    parameter int ID_W = 72
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [ID_W-1:0] card_id,
    output logic            id_bit,
    output logic            done
);
    localparam int CNT_W = $clog2(ID_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } iso_t;

    iso_t iso_q, iso_d;

    always_comb begin
        iso_d = iso_q;
        if (clear) begin
            iso_d.cnt = '0;
        end else if (step && !done) begin
            iso_d.cnt = iso_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iso_q <= '0;
        end else begin
            iso_q <= iso_d;
        end
    end

    always_comb begin
        done   = (iso_q.cnt >= CNT_W'(ID_W));
        id_bit = done ? 1'b0 : card_id[iso_q.cnt];
    end
endmodule

// File: rtl/pnp_rd_mux.sv
module pnp_rd_mux
    import pnp_cfg_pkg::*;
(
    input  logic [7:0] ptr,
    input  logic       in_iso,
    input  logic       iso_bit,
    input  logic       iso_done,
    input  logic [7:0] csn,
    input  logic [7:0] ldn,
    input  logic       res_valid,
    input  logic [7:0] res_data,
    output logic [7:0] value
);
    always_comb begin
        value = 8'h00;
        case (ptr)
            IDX_ISO: begin
                if (in_iso && !iso_done) begin
                    value = iso_bit ? ISO_ONE : ISO_ZERO;
                end
            end
            IDX_RES:  value = res_valid ? res_data : 8'h00;
            IDX_STAT: value = {7'b0, res_valid};
            IDX_CSN:  value = csn;
            IDX_LDN:  value = ldn;
            default:  value = 8'h00;
        endcase
    end
endmodule

// File: rtl/pnp_cfg_fsm.sv
module pnp_cfg_fsm
    import pnp_cfg_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          ID_W       = 72,
    parameter logic [15:0] PTR_PORT   = 16'h0279,
    parameter logic [15:0] WDATA_PORT = 16'h0A79
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_aen,
    input  logic              key_hit,
    input  logic [ID_W-1:0]   card_id,
    input  logic [7:0]        res_data,
    input  logic              res_valid,
    output logic              res_ready,
    output logic [7:0]        bus_rdata,
    output logic              bus_rdrive,
    output logic [1:0]        card_state,
    output logic [7:0]        ldev_num,
    output logic              ld_restore
);
    core_t q, d;

    logic       ptr_we, data_we, data_re;
    logic       wr_allow, rd_allow;
    logic       iso_clear, iso_step, iso_bit, iso_done;
    logic [7:0] mux_val;

    assign wr_allow = (q.st != ST_WFK);
    assign rd_allow = (q.st == ST_ISO) || (q.st == ST_CFG);

    pnp_port_dec #(
        .ADDR_W     (ADDR_W),
        .PTR_PORT   (PTR_PORT),
        .WDATA_PORT (WDATA_PORT)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_aen  (bus_aen),
        .rd_base  (q.rdport),
        .wr_allow (wr_allow),
        .rd_allow (rd_allow),
        .ptr_we   (ptr_we),
        .data_we  (data_we),
        .data_re  (data_re)
    );

    pnp_iso_seq #(.ID_W(ID_W)) u_iso (
        .clk     (clk),
        .rst     (rst),
        .clear   (iso_clear),
        .step    (iso_step),
        .card_id (card_id),
        .id_bit  (iso_bit),
        .done    (iso_done)
    );

    pnp_rd_mux u_mux (
        .ptr       (q.ptr),
        .in_iso    (q.st == ST_ISO),
        .iso_bit   (iso_bit),
        .iso_done  (iso_done),
        .csn       (q.csn),
        .ldn       (q.ldn),
        .res_valid (res_valid),
        .res_data  (res_data),
        .value     (mux_val)
    );

    always_comb begin
        d         = q;
        d.restore = 1'b0;
        iso_clear = 1'b0;
        iso_step  = data_re && (q.ptr == IDX_ISO) && (q.st == ST_ISO);

        if (key_hit && (q.st == ST_WFK)) begin
            d.st = ST_SLEEP;
        end

        if (ptr_we) begin
            d.ptr = bus_wdata;
        end

        if (data_we) begin
            case (q.ptr)
                IDX_RDPORT: begin
                    if (q.st == ST_ISO) begin
                        d.rdport = bus_wdata;
                    end
                end
                IDX_CTRL: begin
                    if (bus_wdata[0]) begin
                        d.restore = 1'b1;
                    end
                    if (bus_wdata[2]) begin
                        d.csn    = 8'h00;
                        d.rdport = 8'h00;
                    end
                    if (bus_wdata[1]) begin
                        d.st = ST_WFK;
                    end
                end
                IDX_WAKE: begin
                    if (bus_wdata == q.csn) begin
                        d.st      = (bus_wdata == 8'h00) ? ST_ISO : ST_CFG;
                        iso_clear = 1'b1;
                    end else begin
                        d.st = ST_SLEEP;
                    end
                end
                IDX_CSN: begin
                    if ((q.st == ST_ISO) || (q.st == ST_CFG)) begin
                        d.csn = bus_wdata;
                        d.st  = ST_CFG;
                    end
                end
                IDX_LDN: begin
                    if (q.st == ST_CFG) begin
                        d.ldn = bus_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_WFK, ptr: 8'h00, csn: 8'h00, ldn: 8'h00,
                   rdport: 8'h00, restore: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdrive = data_re;
        bus_rdata  = data_re ? mux_val : 8'h00;
        res_ready  = data_re && (q.ptr == IDX_RES) && res_valid;
        card_state = q.st;
        ldev_num   = q.ldn;
        ld_restore = q.restore;
    end
endmodule

// File: rtl/pnp_cfg_chk.sv
module pnp_cfg_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_aen,
    input logic       bus_wr,
    input logic       key_hit,
    input logic       bus_rdrive,
    input logic       res_ready,
    input logic       res_valid,
    input logic [1:0] card_state,
    input logic [7:0] ldev_num,
    input logic       ld_restore
);
    AST_AEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_aen |-> (!bus_rdrive && !res_ready));                          // R3
    AST_WFK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0) |-> !bus_rdrive);                             // R2
    AST_KEY_TO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        ((card_state == 2'd0) && key_hit) |=> (card_state == 2'd1));       // R2
    AST_WFK_EXIT: assert property (@(posedge clk) disable iff (rst)
        (card_state == 2'd0) |=> (card_state == 2'd0 || card_state == 2'd1)); // R2
    AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        res_ready |-> (res_valid && bus_rdrive));                          // R11
    AST_LDN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(ldev_num));                                    // R9
    AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ld_restore |=> !ld_restore);                                       // R10
endmodule

bind pnp_cfg_fsm pnp_cfg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_aen    (bus_aen),
    .bus_wr     (bus_wr),
    .key_hit    (key_hit),
    .bus_rdrive (bus_rdrive),
    .res_ready  (res_ready),
    .res_valid  (res_valid),
    .card_state (card_state),
    .ldev_num   (ldev_num),
    .ld_restore (ld_restore)
);

// File: tb/pnp_cfg_fsm_bench.sv
module pnp_cfg_fsm_bench;
    localparam logic [15:0] PP = 16'h0279;
    localparam logic [15:0] WP = 16'h0A79;
    localparam logic [71:0] ID = 72'hC3_5A96_0F1E_2D3C_4B87;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_aen = 1'b0, key_hit = 1'b0;
    logic [7:0]  res_data = '0;
    logic        res_valid = 1'b0;
    logic        res_ready, bus_rdrive, ld_restore;
    logic [7:0]  bus_rdata, ldev_num;
    logic [1:0]  card_state;

    int tests = 0;
    int fails = 0;
    logic [15:0] rp = 16'h0003;

    always #4 clk = ~clk;

    pnp_cfg_fsm u_pnp_cfg_fsm (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_aen(bus_aen), .key_hit(key_hit),
        .card_id(ID), .res_data(res_data), .res_valid(res_valid),
        .res_ready(res_ready), .bus_rdata(bus_rdata), .bus_rdrive(bus_rdrive),
        .card_state(card_state), .ldev_num(ldev_num), .ld_restore(ld_restore)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] v, input bit aen);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_aen = aen; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_aen = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input bit aen,
                            output logic [7:0] v, output bit drv, output bit pop);
        @(negedge clk);
        bus_addr = a; bus_aen = aen; bus_rd = 1'b1;
        #1;
        v = bus_rdata; drv = bus_rdrive; pop = res_ready;
        @(negedge clk);
        bus_rd = 1'b0; bus_aen = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
        bus_write(PP, idx, 1'b0);
        bus_write(WP, v, 1'b0);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v, output bit drv, output bit pop);
        bus_write(PP, idx, 1'b0);
        bus_read(rp, 1'b0, v, drv, pop);
    endtask

    task automatic pulse_key();
        @(negedge clk); key_hit = 1'b1;
        @(negedge clk); key_hit = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(card_state == 2'd0, "R1 state in reset", card_state, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(card_state == 2'd0, "R1 state after reset", card_state, 0);
        chk(ldev_num == 8'h00, "R1 ldn after reset", ldev_num, 0);
        chk(bus_rdrive == 1'b0, "R1 no drive", bus_rdrive, 0);
    endtask

    task automatic t_wfk();
        logic [7:0] v; bit drv, pop;
        wr_reg(8'h06, 8'h05);
        chk(card_state == 2'd0, "R2 write ignored in wfk", card_state, 0);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(!drv, "R2 read not driven in wfk", drv, 0);
        pulse_key();
        chk(card_state == 2'd1, "R2 key to sleep", card_state, 1);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(!drv, "R5 read not driven in sleep", drv, 0);
    endtask

    task automatic t_wake_iso();
        logic [7:0] v; bit drv, pop;
        wr_reg(8'h03, 8'h00);
        chk(card_state == 2'd2, "R6 wake zero to isolation", card_state, 2);
        wr_reg(8'h00, 8'h80);
        rp = 16'h0203;
        bus_read(rp, 1'b0, v, drv, pop);
        chk(drv && v == 8'h00, "R5 relocated port, R12 reg0 reads 0", {drv, v}, 9'h100);
    endtask

    task automatic t_isolation();
        logic [7:0] v; bit drv, pop;
        bus_write(PP, 8'h01, 1'b0);
        for (int i = 0; i < 72; i++) begin
            bus_read(rp, 1'b0, v, drv, pop);
            chk(v == (ID[i] ? 8'h55 : 8'hAA), $sformatf("R7 iso bit %0d", i), v, ID[i] ? 8'h55 : 8'hAA);
        end
        bus_read(rp, 1'b0, v, drv, pop);
        chk(v == 8'h00, "R7 after last bit", v, 0);
    endtask

    task automatic t_csn_ldn();
        logic [7:0] v; bit drv, pop;
        wr_reg(8'h06, 8'h03);
        chk(card_state == 2'd3, "R8 csn write to config", card_state, 3);
        rd_reg(8'h06, v, drv, pop);
        chk(v == 8'h03, "R8 csn readback", v, 3);
        wr_reg(8'h07, 8'h02);
        chk(ldev_num == 8'h02, "R9 ldn output", ldev_num, 2);
        bus_write(WP, 8'h04, 1'b0);
        chk(ldev_num == 8'h04, "R4 repeat write without pointer", ldev_num, 4);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(v == 8'h04, "R4 R9 ldn readback", v, 4);
    endtask

    task automatic t_aen();
        logic [7:0] v; bit drv, pop;
        bus_write(PP, 8'h06, 1'b1);
        bus_write(WP, 8'h09, 1'b1);
        chk(ldev_num == 8'h04, "R3 aen write ignored", ldev_num, 4);
        bus_read(rp, 1'b1, v, drv, pop);
        chk(!drv, "R3 aen read not driven", drv, 0);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(v == 8'h04, "R3 pointer kept", v, 4);
    endtask

    task automatic t_resource();
        logic [7:0] v; bit drv, pop;
        rd_reg(8'h05, v, drv, pop);
        chk(v == 8'h00, "R11 status not ready", v, 0);
        rd_reg(8'h04, v, drv, pop);
        chk(v == 8'h00 && !pop, "R11 no byte no pop", {pop, v}, 0);
        res_valid = 1'b1; res_data = 8'hA5;
        rd_reg(8'h05, v, drv, pop);
        chk(v == 8'h01, "R11 status ready", v, 1);
        rd_reg(8'h04, v, drv, pop);
        chk(v == 8'hA5 && pop, "R11 byte and pop", {pop, v}, 9'h1A5);
        res_valid = 1'b0;
    endtask

    task automatic t_unimpl();
        logic [7:0] v; bit drv, pop;
        rd_reg(8'h20, v, drv, pop);
        chk(drv && v == 8'h00, "R12 unimplemented reads 0", {drv, v}, 9'h100);
        rd_reg(8'h03, v, drv, pop);
        chk(v == 8'h00, "R12 wake reads 0", v, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] v; bit drv, pop;
        wr_reg(8'h02, 8'h01);
        chk(ld_restore, "R10 restore pulse", ld_restore, 1);
        @(negedge clk);
        chk(!ld_restore, "R10 restore clears", ld_restore, 0);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(v == 8'h00, "R10 ctrl reads 0", v, 0);
        wr_reg(8'h00, 8'h90);
        bus_read(16'h0243, 1'b0, v, drv, pop);
        chk(!drv, "R5 reg0 ignored outside isolation", drv, 0);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(drv, "R5 old port still live", drv, 1);
        wr_reg(8'h02, 8'h02);
        chk(card_state == 2'd0, "R10 bit1 to wfk", card_state, 0);
        chk(ldev_num == 8'h04, "R10 ldn kept", ldev_num, 4);
        pulse_key();
        wr_reg(8'h03, 8'h03);
        chk(card_state == 2'd3, "R10 csn kept across wfk", card_state, 3);
        wr_reg(8'h02, 8'h04);
        bus_read(rp, 1'b0, v, drv, pop);
        chk(!drv, "R10 bit2 clears read port", drv, 0);
        rp = 16'h0003;
        bus_read(rp, 1'b0, v, drv, pop);
        chk(drv, "R10 zero read port live", drv, 1);
        rd_reg(8'h06, v, drv, pop);
        chk(v == 8'h00, "R10 bit2 clears csn", v, 0);
    endtask

    task automatic t_wake_variants();
        logic [7:0] v; bit drv, pop;
        wr_reg(8'h06, 8'h03);
        wr_reg(8'h03, 8'h07);
        chk(card_state == 2'd1, "R6 mismatch to sleep", card_state, 1);
        wr_reg(8'h03, 8'h03);
        chk(card_state == 2'd3, "R6 match nonzero to config", card_state, 3);
        wr_reg(8'h06, 8'h00);
        wr_reg(8'h03, 8'h00);
        chk(card_state == 2'd2, "R6 match zero to isolation", card_state, 2);
        rd_reg(8'h01, v, drv, pop);
        chk(v == (ID[0] ? 8'h55 : 8'hAA), "R6 walk restarts at bit 0", v, ID[0] ? 8'h55 : 8'hAA);
    endtask

    initial begin
        t_reset();
        t_wfk();
        t_wake_iso();
        t_isolation();
        t_csn_ldn();
        t_aen();
        t_resource();
        t_unimpl();
        t_ctrl();
        t_wake_variants();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule